// File: doc/BRIEF.md
# Burst Line Buffer for an SDRAM Slave Port

This block sits between one word-wide bus slave port and the burst request port of an SDRAM scheduler. It keeps one line-sized read buffer and one line-sized write buffer. A line is eight 32-bit words. A read that misses fetches the whole line in a single burst and keeps it. Reads that land in the kept line are answered locally, one cycle after acceptance, with no memory traffic.

Writes are taken into the write buffer in the same cycle they are presented, as long as the buffer is empty or already holds that line. Each write merges in byte by byte under its byte enables. Once every byte of the buffered line is valid, the block sends one full-line write burst. A write to a different line while partial data is held first pushes out only the valid bytes as a masked burst, and is accepted afterwards.

The two buffers are kept consistent with each other. An accepted write also updates the read line when it targets that line. A read, or a line fill, takes bytes pending in the write buffer in preference to older data.

Top module: `sdram_burst_buf`

## Requirements
- R1: After synchronous reset, no memory request and no read response is asserted, the read line is empty (the first read of any address causes a burst read), and the write buffer is empty.
- R2: A read whose line is not held issues exactly one read burst (`mem_req_we`=0) carrying the line index `bus_addr[15:3]`. After `mem_rvalid` returns the line, the read is accepted and answered.
- R3: A read to the held line is accepted in the cycle it is presented and issues no memory request. `bus_rvalid` is high in the following cycle, with the addressed word (word offset `bus_addr[2:0]`) on `bus_rdata`.
- R4: A write is accepted in the cycle it is presented (`bus_ready`=1) when the write buffer is empty or holds the same line.
- R5: Writes to the buffered line merge under their byte enables (`bus_be[k]` covers bits 8k+7..8k). No memory write is issued while the line is not completely valid.
- R6: When all 32 bytes of the write buffer are valid, exactly one write burst is issued with `mem_req_wmask` all ones and the merged line data. Bus requests stall until it completes.
- R7: A write to another line while the buffer holds partial data is held off (`bus_ready`=0). The block first issues one write burst whose mask bit 4w+k is set only for valid byte k of word w, and accepts the write after that burst.
- R8: A write to the line held in the read buffer updates that line, so later reads to it still hit and return the written bytes.
- R9: Read data and line fills take bytes pending in the write buffer over read-buffer or SDRAM bytes.
- R10: While `mem_req_valid` is high, `bus_ready` is low. A request stays asserted with stable kind and line index until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address (bits 2:0 select the word in the line) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for writes |
| bus_ready | output | 1 | Request accepted this cycle |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| mem_req_valid | output | 1 | Burst request to the scheduler |
| mem_req_we | output | 1 | 1 = write burst, 0 = read burst |
| mem_req_addr | output | 13 | Line index |
| mem_req_wdata | output | 256 | Write burst line data |
| mem_req_wmask | output | 32 | Write burst byte mask |
| mem_req_ready | input | 1 | Scheduler takes the request |
| mem_rvalid | input | 1 | Read burst data returned |
| mem_rdata | input | 256 | Read burst line data |

## Verification
The assertions assume two things. First, a bus master keeps `bus_valid` and its address, data and enables steady until `bus_ready`. Second, the scheduler returns `mem_rvalid` only after it has taken a read burst, and only once per read burst.

The bench's bus tasks hold each request until it is accepted. Its memory model asserts `mem_req_ready` at random but raises `mem_rvalid` once, a fixed delay after each read handshake. The stimulus mixes directed line-crossing cases with seeded random traffic over four lines. This keeps fills, merges, full writes and forced flushes interleaving within those rules.

// File: rtl/sdbuf_pkg.sv
package sdbuf_pkg;
    localparam int DATA_W     = 32;
    localparam int BPW        = DATA_W / 8;
    localparam int LINE_WORDS = 8;
    localparam int OFF_W      = $clog2(LINE_WORDS);
    localparam int ADDR_W     = 16;
    localparam int TAG_W      = ADDR_W - OFF_W;
    localparam int LINE_W     = DATA_W * LINE_WORDS;
    localparam int LMASK_W    = BPW * LINE_WORDS;

    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [OFF_W-1:0]   off_t;
    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [BPW-1:0]     be_t;
    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [LMASK_W-1:0] lmask_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_FILL_REQ,
        ST_FILL_WAIT
    } ctl_state_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        line_t data;
    } rline_t;

    typedef struct packed {
        tag_t   tag;
        line_t  data;
        lmask_t mask;
    } wline_t;

    function automatic lmask_t place_be(off_t off, be_t be);
        return lmask_t'(be) << (int'(off) * BPW);
    endfunction

    function automatic line_t place_word(off_t off, word_t w);
        return line_t'(w) << (int'(off) * DATA_W);
    endfunction

    function automatic line_t mask_bits(lmask_t m);
        line_t b;
        for (int i = 0; i < LMASK_W; i++) b[i*8 +: 8] = {8{m[i]}};
        return b;
    endfunction

    function automatic line_t overlay(line_t base, line_t top, lmask_t m);
        line_t b;
        b = mask_bits(m);
        return (base & ~b) | (top & b);
    endfunction

    function automatic word_t pick_word(line_t l, off_t off);
        return l[int'(off)*DATA_W +: DATA_W];
    endfunction
endpackage

// File: rtl/sdbuf_wr_merge.sv
module sdbuf_wr_merge
    import sdbuf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   merge_en,
    input  tag_t   merge_tag,
    input  off_t   merge_off,
    input  word_t  merge_data,
    input  be_t    merge_be,
    input  logic   clear,
    output wline_t wl,
    output logic   full,
    output logic   empty
);
    wline_t wl_q;
    lmask_t add_mask;

    assign add_mask = place_be(merge_off, merge_be);

    always_ff @(posedge clk) begin
        if (rst) begin
            wl_q.mask <= '0;
            wl_q.tag  <= '0;
            wl_q.data <= '0;
        end else if (clear) begin
            wl_q.mask <= '0;
        end else if (merge_en) begin
            wl_q.tag  <= merge_tag;
            wl_q.data <= overlay(wl_q.data, place_word(merge_off, merge_data), add_mask);
            wl_q.mask <= wl_q.mask | add_mask;
        end
    end

    assign wl    = wl_q;
    assign full  = &wl_q.mask;
    assign empty = ~|wl_q.mask;

    assert_merge_same_line_R5: assert property (@(posedge clk) disable iff (rst)
        merge_en && !empty |-> merge_tag == wl_q.tag);
    assert_no_merge_when_full_R6: assert property (@(posedge clk) disable iff (rst)
        merge_en |-> !full);
    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
        clear |=> empty);
endmodule

// File: rtl/sdbuf_rd_line.sv
module sdbuf_rd_line
    import sdbuf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fill_en,
    input  tag_t   fill_tag,
    input  line_t  fill_data,
    input  logic   upd_en,
    input  tag_t   upd_tag,
    input  off_t   upd_off,
    input  word_t  upd_data,
    input  be_t    upd_be,
    output rline_t rl
);
    rline_t rl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rl_q.valid <= 1'b0;
            rl_q.tag   <= '0;
            rl_q.data  <= '0;
        end else if (fill_en) begin
            rl_q.valid <= 1'b1;
            rl_q.tag   <= fill_tag;
            rl_q.data  <= fill_data;
        end else if (upd_en) begin
            rl_q.data <= overlay(rl_q.data, place_word(upd_off, upd_data),
                                 place_be(upd_off, upd_be));
        end
    end

    assign rl = rl_q;

    assert_update_only_on_hit_R8: assert property (@(posedge clk) disable iff (rst)
        upd_en |-> rl_q.valid && upd_tag == rl_q.tag);
    assert_fill_not_with_update_R8: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !upd_en);
    assert_fill_sets_line_R2: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> rl_q.valid && rl_q.tag == $past(fill_tag));
endmodule

// File: rtl/sdbuf_ctrl.sv
module sdbuf_ctrl
    import sdbuf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bus_valid,
    input  logic   bus_we,
    input  tag_t   req_tag,
    input  off_t   req_off,
    input  be_t    req_be,
    output logic   bus_ready,
    output logic   bus_rvalid,
    output word_t  bus_rdata,
    input  rline_t rl,
    input  wline_t wl,
    input  logic   wb_full,
    input  logic   wb_empty,
    output logic   merge_en,
    output logic   upd_en,
    output logic   wb_clear,
    output logic   fill_en,
    output tag_t   miss_tag,
    output logic   mem_req_valid,
    output logic   mem_req_we,
    output tag_t   mem_req_tag,
    input  logic   mem_req_ready,
    input  logic   mem_rvalid
);
    ctl_state_t st, nxt;
    tag_t       miss_tag_q;
    logic       rb_hit, wb_hit;
    line_t      view_line;
    logic       rd_accept;

    assign rb_hit    = rl.valid && (rl.tag == req_tag);
    assign wb_hit    = !wb_empty && (wl.tag == req_tag);
    assign view_line = overlay(rl.data, wl.data, wb_hit ? wl.mask : '0);
    assign rd_accept = bus_ready && !bus_we;

    always_comb begin
        nxt           = st;
        bus_ready     = 1'b0;
        merge_en      = 1'b0;
        upd_en        = 1'b0;
        wb_clear      = 1'b0;
        fill_en       = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_tag   = miss_tag_q;
        unique case (st)
            ST_IDLE: begin
                if (wb_full) begin
                    nxt = ST_FLUSH;
                end else if (bus_valid) begin
                    if (bus_we) begin
                        if (wb_empty || wb_hit) begin
                            bus_ready = 1'b1;
                            merge_en  = 1'b1;
                            upd_en    = rb_hit;
                        end else begin
                            nxt = ST_FLUSH;
                        end
                    end else if (rb_hit) begin
                        bus_ready = 1'b1;
                    end else begin
                        nxt = ST_FILL_REQ;
                    end
                end
            end
            ST_FLUSH: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_tag   = wl.tag;
                if (mem_req_ready) begin
                    wb_clear = 1'b1;
                    nxt      = ST_IDLE;
                end
            end
            ST_FILL_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) nxt = ST_FILL_WAIT;
            end
            ST_FILL_WAIT: begin
                if (mem_rvalid) begin
                    fill_en = 1'b1;
                    nxt     = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            miss_tag_q <= '0;
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            st         <= nxt;
            bus_rvalid <= rd_accept;
            if (rd_accept) bus_rdata <= pick_word(view_line, req_off);
            if (st == ST_IDLE && nxt == ST_FILL_REQ) miss_tag_q <= req_tag;
        end
    end

    assign miss_tag = miss_tag_q;

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> !mem_req_valid && !bus_rvalid);
    assert_miss_reads_line_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_we |-> mem_req_tag != rl.tag || !rl.valid);
    assert_read_hit_latency_R3: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_ready && !bus_we |=> bus_rvalid);
    assert_write_accept_R4: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE && bus_valid && bus_we && wb_empty |-> bus_ready);
    assert_partial_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_we && $rose(mem_req_valid) |-> $past(wb_full) || $past(bus_valid && bus_we));
    assert_full_stalls_R6: assert property (@(posedge clk) disable iff (rst)
        wb_full |-> !bus_ready);
    assert_other_line_held_R7: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_we && !wb_empty && wl.tag != req_tag |-> !bus_ready);
    assert_stall_during_req_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !bus_ready);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we) && $stable(mem_req_tag));
    assert_be_known_R5: assert property (@(posedge clk) disable iff (rst)
        merge_en |-> !$isunknown(req_be));
endmodule

// File: rtl/sdram_burst_buf.sv
module sdram_burst_buf
    import sdbuf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [BPW-1:0]     bus_be,
    output logic               bus_ready,
    output logic               bus_rvalid,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               mem_req_valid,
    output logic               mem_req_we,
    output logic [TAG_W-1:0]   mem_req_addr,
    output logic [LINE_W-1:0]  mem_req_wdata,
    output logic [LMASK_W-1:0] mem_req_wmask,
    input  logic               mem_req_ready,
    input  logic               mem_rvalid,
    input  logic [LINE_W-1:0]  mem_rdata
);
    tag_t   req_tag;
    off_t   req_off;
    rline_t rl;
    wline_t wl;
    logic   wb_full, wb_empty;
    logic   merge_en, upd_en, wb_clear, fill_en;
    tag_t   miss_tag;
    line_t  fill_line;

    assign req_tag = bus_addr[ADDR_W-1:OFF_W];
    assign req_off = bus_addr[OFF_W-1:0];

    assign fill_line = overlay(mem_rdata, wl.data,
                               (!wb_empty && wl.tag == miss_tag) ? wl.mask : '0);

    sdbuf_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .bus_valid     (bus_valid),
        .bus_we        (bus_we),
        .req_tag       (req_tag),
        .req_off       (req_off),
        .req_be        (bus_be),
        .bus_ready     (bus_ready),
        .bus_rvalid    (bus_rvalid),
        .bus_rdata     (bus_rdata),
        .rl            (rl),
        .wl            (wl),
        .wb_full       (wb_full),
        .wb_empty      (wb_empty),
        .merge_en      (merge_en),
        .upd_en        (upd_en),
        .wb_clear      (wb_clear),
        .fill_en       (fill_en),
        .miss_tag      (miss_tag),
        .mem_req_valid (mem_req_valid),
        .mem_req_we    (mem_req_we),
        .mem_req_tag   (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rvalid    (mem_rvalid)
    );

    sdbuf_wr_merge u_wbuf (
        .clk        (clk),
        .rst        (rst),
        .merge_en   (merge_en),
        .merge_tag  (req_tag),
        .merge_off  (req_off),
        .merge_data (bus_wdata),
        .merge_be   (bus_be),
        .clear      (wb_clear),
        .wl         (wl),
        .full       (wb_full),
        .empty      (wb_empty)
    );

    sdbuf_rd_line u_rbuf (
        .clk       (clk),
        .rst       (rst),
        .fill_en   (fill_en),
        .fill_tag  (miss_tag),
        .fill_data (fill_line),
        .upd_en    (upd_en),
        .upd_tag   (req_tag),
        .upd_off   (req_off),
        .upd_data  (bus_wdata),
        .upd_be    (bus_be),
        .rl        (rl)
    );

    assign mem_req_wdata = wl.data;
    assign mem_req_wmask = wl.mask;

    assert_full_mask_on_full_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_we |-> mem_req_wmask != '0);
endmodule

// File: tb/tb_sdram_burst_buf.sv
module tb_sdram_burst_buf;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_valid = 1'b0;
    logic         bus_we = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [3:0]   bus_be = '0;
    logic         bus_ready, bus_rvalid;
    logic [31:0]  bus_rdata;
    logic         mem_req_valid, mem_req_we;
    logic [12:0]  mem_req_addr;
    logic [255:0] mem_req_wdata;
    logic [31:0]  mem_req_wmask;
    logic         mem_req_ready = 1'b0;
    logic         mem_rvalid = 1'b0;
    logic [255:0] mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int cyc = 0;
    logic [31:0] last_mask = '0;

    logic [7:0] shadow [int];
    logic [7:0] store  [int];
    logic [31:0] exp_q [$];
    bit exp_rv = 0;
    bit pend = 0;
    int pend_cnt = 0;
    int pend_tag = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdram_burst_buf dut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_wmask(mem_req_wmask), .mem_req_ready(mem_req_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 13 + 7) & 255);
    endfunction

    function automatic logic [7:0] sh_get(int a);
        return shadow.exists(a) ? shadow[a] : init_byte(a);
    endfunction

    function automatic logic [7:0] st_get(int a);
        return store.exists(a) ? store[a] : init_byte(a);
    endfunction

    function automatic logic [31:0] sh_word(int wa);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) w[i*8 +: 8] = sh_get(wa * 4 + i);
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // reference model, compared every clock at the falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (bus_rvalid !== exp_rv) begin
                fails++;
                $display("FAIL R3 rvalid actual=%0b expected=%0b", bus_rvalid, exp_rv);
            end
            if (bus_rvalid && exp_q.size() > 0) begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(bus_rdata === e, "R9 read data", 256'(bus_rdata), 256'(e));
            end
            exp_rv = 0;
            if (mem_req_valid && bus_ready) begin
                fails++;
                $display("FAIL R10 bus_ready=1 actual with request open, expected 0");
            end
            if (bus_valid && bus_ready) begin
                if (bus_we) begin
                    for (int i = 0; i < 4; i++)
                        if (bus_be[i]) shadow[int'(bus_addr) * 4 + i] = bus_wdata[i*8 +: 8];
                end else begin
                    exp_q.push_back(sh_word(int'(bus_addr)));
                    exp_rv = 1;
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    bit ok;
                    ok = 1;
                    for (int j = 0; j < 32; j++)
                        if (mem_req_wmask[j]) begin
                            if (mem_req_wdata[j*8 +: 8] !== sh_get(int'(mem_req_addr) * 32 + j)) ok = 0;
                            store[int'(mem_req_addr) * 32 + j] = mem_req_wdata[j*8 +: 8];
                        end
                    check(ok, "R6 burst data", mem_req_wdata, 256'(mem_req_addr));
                    wr_cnt++;
                    last_mask = mem_req_wmask;
                end else begin
                    rd_cnt++;
                    pend = 1;
                    pend_cnt = 3;
                    pend_tag = int'(mem_req_addr);
                end
            end
        end
    end

    // memory model
    always @(posedge clk) begin
        #1;
        mem_req_ready = ($urandom_range(0, 2) != 0);
        mem_rvalid = 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                for (int b = 0; b < 32; b++) mem_rdata[b*8 +: 8] = st_get(pend_tag * 32 + b);
                mem_rvalid = 1'b1;
                pend = 0;
            end else pend_cnt--;
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    task automatic bus_op(input bit we, input int a, input logic [31:0] d,
                          input logic [3:0] be, output bit first_ready);
        @(posedge clk); #1;
        bus_valid = 1; bus_we = we; bus_addr = 16'(a); bus_wdata = d; bus_be = be;
        @(negedge clk);
        first_ready = bus_ready;
        while (!bus_ready) @(negedge clk);
        @(posedge clk); #1;
        bus_valid = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
        bit fr;
        bus_op(1, a, d, be, fr);
    endtask

    task automatic rd(input int a);
        bit fr;
        bus_op(0, a, 32'h0, 4'h0, fr);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        bit fr;
        int rs, ws;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(mem_req_valid == 0 && bus_rvalid == 0, "R1 reset outputs",
              256'({mem_req_valid, bus_rvalid}), 256'(0));

        // R2: first read misses and fetches one burst
        rs = rd_cnt;
        rd(16'h10);
        check(rd_cnt == rs + 1, "R2 one read burst on miss", 256'(rd_cnt - rs), 256'(1));
        // R3: hits in the same line
        rs = rd_cnt;
        rd(16'h13); rd(16'h17);
        check(rd_cnt == rs, "R3 no burst on hit", 256'(rd_cnt - rs), 256'(0));

        // R4/R5: merge writes into line 4
        ws = wr_cnt;
        bus_op(1, 16'h21, 32'hAABBCCDD, 4'b0011, fr);
        check(fr == 1, "R4 write accepted at once", 256'(fr), 256'(1));
        wr(16'h21, 32'h11223344, 4'b1100);
        wr(16'h22, 32'h55667788, 4'b1111);
        check(wr_cnt == ws, "R5 no write while partial", 256'(wr_cnt - ws), 256'(0));
        // R9: read miss on line with pending bytes
        rd(16'h21); rd(16'h23);
        // R6: complete the line
        wr(16'h20, 32'h01020304, 4'hF);
        for (int w = 3; w < 7; w++) wr(16'h20 + w, 32'hC0DE0000 + w, 4'hF);
        check(wr_cnt == ws, "R5 no write before full", 256'(wr_cnt - ws), 256'(0));
        wr(16'h27, 32'hFEEDF00D, 4'hF);
        idle(12);
        check(wr_cnt == ws + 1, "R6 one full burst", 256'(wr_cnt - ws), 256'(1));
        check(last_mask == 32'hFFFF_FFFF, "R6 full mask", 256'(last_mask), 256'hFFFF_FFFF);

        // R8: write into held read line, then read it back as a hit
        rd(16'h20);
        rs = rd_cnt;
        wr(16'h24, 32'h9A9B9C9D, 4'b0101);
        rd(16'h24);
        check(rd_cnt == rs, "R8 read line still hit", 256'(rd_cnt - rs), 256'(0));
        // R7: other line forces masked flush first
        ws = wr_cnt;
        bus_op(1, 16'h31, 32'h31313131, 4'hF, fr);
        check(fr == 0, "R7 write held off", 256'(fr), 256'(0));
        check(wr_cnt == ws + 1, "R7 one masked burst", 256'(wr_cnt - ws), 256'(1));
        check(last_mask == 32'h0005_0000, "R7 partial mask", 256'(last_mask), 256'h0005_0000);
        rd(16'h24);
        check(rd_cnt == rs, "R8 no refetch after flush", 256'(rd_cnt - rs), 256'(0));
        rd(16'h31); rd(16'h30);

        // mixed traffic over four lines
        for (int k = 0; k < 300; k++) begin
            int a;
            a = 16'h20 + int'($urandom_range(0, 31));
            if ($urandom_range(0, 1) == 1) wr(a, $urandom, 4'($urandom_range(1, 15)));
            else rd(a);
        end
        idle(20);
        check(exp_q.size() == 0, "R3 all reads answered", 256'(exp_q.size()), 256'(0));
        finish_run();
    end
endmodule